// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with HI/LO Result Registers

This block is the integer multiply and divide engine of a 32-bit RISC core. A caller presents an operation code and two 32-bit operands with a one-cycle `start_i` strobe. Multiplies and divides then run for a fixed number of cycles, and `busy_o` stays high throughout. The 64-bit outcome lands in two dedicated 32-bit result registers, HI and LO, and `done_o` pulses for one cycle. The same strobe also carries direct writes into HI or LO. A combinational read port returns either register at any time.

The multiplier is a shift-and-add array that retires `MUL_STEP` multiplier bits per cycle. The divider is a restoring divider that produces one quotient bit per cycle. Both work on operand magnitudes, and a final cycle applies the signs. A divide with a zero divisor runs for the normal time but leaves HI and LO untouched.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, HI and LO hold 0, and `busy_o` and `done_o` are low.
- R2: op_i=0 (signed multiply) forms the full 64-bit two's-complement product. LO receives bits 31:0 and HI receives bits 63:32.
- R3: op_i=1 (unsigned multiply) forms the 64-bit unsigned product, with the same HI/LO split as R2.
- R4: op_i=2 (signed divide) puts the quotient, truncated toward zero, in LO. It puts the remainder in HI, and the remainder carries the sign of the dividend.
- R5: op_i=3 (unsigned divide) puts the quotient in LO and the remainder in HI.
- R6: A divide (op_i=2 or 3) with `opb_i`=0 leaves HI and LO unchanged, and still pulses `done_o` after the normal divide latency.
- R7: A signed divide of 0x80000000 by 0xFFFFFFFF gives LO=0x80000000 and HI=0, with no other effect.
- R8: op_i=4 writes `opa_i` into HI and op_i=5 writes `opa_i` into LO, both at the accepting clock edge. Neither raises `busy_o` nor pulses `done_o`.
- R9: `rd_data_o` shows HI when `rd_hi_i`=1 and LO when `rd_hi_i`=0, combinationally.
- R10: A multiply or divide is accepted on the edge where `start_i`=1 and `busy_o`=0. `busy_o` is high from the next cycle until the result is written. `done_o` is high for exactly one cycle, with `busy_o` low. A divide's result and `done_o` appear 33 edges after the accepting edge, and a multiply's appear WIDTH/MUL_STEP+1 edges after it (9 by default).
- R11: While `busy_o` is high, any `start_i` is ignored, moves included: HI and LO stay frozen and no extra `done_o` appears.
- R12: op_i=6 and op_i=7 have no effect: `busy_o` stays low, no `done_o` appears, and HI and LO are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Operation strobe |
| op_i | input | 3 | Operation code (see requirements) |
| opa_i | input | 32 | Operand A: multiplicand, dividend or move data |
| opb_i | input | 32 | Operand B: multiplier or divisor |
| rd_hi_i | input | 1 | Read select: 1 selects HI, 0 selects LO |
| busy_o | output | 1 | A multiply or divide is in progress |
| done_o | output | 1 | One-cycle pulse when a result is written |
| rd_data_o | output | 32 | Current HI or LO value |

## Verification
Each long operation has a fixed deadline. A divide's result is due 33 edges after the accepting edge, and a multiply's is due 9 edges after it. The driver notes the cycle count when it raises `start_i` and queues the expected HI/LO pair with that deadline. The monitor checks that `done_o` rises in exactly that cycle, then reads both registers back through the read port in the same low clock phase. Moves and ignored strobes have no done pulse, so their effect is read back one cycle after the accepting edge.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [2:0] {
    OP_MUL_S  = 3'd0,
    OP_MUL_U  = 3'd1,
    OP_DIV_S  = 3'd2,
    OP_DIV_U  = 3'd3,
    OP_SET_HI = 3'd4,
    OP_SET_LO = 3'd5,
    OP_RSV6   = 3'd6,
    OP_RSV7   = 3'd7
  } md_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } md_state_e;
endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
  import muldiv_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  logic [CNT_W-1:0] iters_i,
  output logic             step_o,
  output logic             fix_o,
  output logic             busy_o,
  output logic             done_o
);
  md_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (launch_i) begin
          state_q <= ST_RUN;
          cnt_q   <= iters_i;
        end
        ST_RUN: begin
          if (cnt_q == '0) state_q <= ST_FIX;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        ST_FIX: begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign step_o = (state_q == ST_RUN);
  assign fix_o  = (state_q == ST_FIX);
  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

// File: rtl/muldiv_mul.sv
module muldiv_mul #(
  parameter int W    = 32,
  parameter int STEP = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic [2*W-1:0] prod_o
);
  localparam int SW = W + STEP;

  logic [W-1:0]   mcand_q;
  logic [2*W-1:0] prod_q;
  logic [SW-1:0]  row [STEP];
  logic [SW-1:0]  sum;

  // one partial-product row per multiplier bit retired this cycle
  for (genvar k = 0; k < STEP; k++) begin : g_row
    assign row[k] = prod_q[k] ? ({{STEP{1'b0}}, mcand_q} << k) : '0;
  end

  always_comb begin
    sum = {{STEP{1'b0}}, prod_q[2*W-1:W]};
    for (int k = 0; k < STEP; k++) sum = sum + row[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q <= '0;
      prod_q  <= '0;
    end else if (load_i) begin
      mcand_q <= mcand_i;
      prod_q  <= {{W{1'b0}}, mplier_i};
    end else if (step_i) begin
      prod_q  <= {sum, prod_q[W-1:STEP]};
    end
  end

  assign prod_o = prod_q;
endmodule

// File: rtl/muldiv_div.sv
module muldiv_div #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  logic [W-1:0] quo_q, rem_q, dvs_q;
  logic [W:0]   sh, dif;
  logic         ge;

  assign sh  = {rem_q, quo_q[W-1]};
  assign ge  = (sh >= {1'b0, dvs_q});
  assign dif = sh - {1'b0, dvs_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quo_q <= '0;
      rem_q <= '0;
      dvs_q <= '0;
    end else if (load_i) begin
      quo_q <= dvd_i;
      rem_q <= '0;
      dvs_q <= dvs_i;
    end else if (step_i) begin
      rem_q <= ge ? dif[W-1:0] : sh[W-1:0];
      quo_q <= {quo_q[W-2:0], ge};
    end
  end

  assign quo_o = quo_q;
  assign rem_o = rem_q;

  // restoring invariant: partial remainder stays below a nonzero divisor
  p_rem_below_dvs_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dvs_q != '0) |-> (rem_q < dvs_q));
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int WIDTH    = 32,
  parameter int MUL_STEP = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [2:0]       op_i,
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  input  logic             rd_hi_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] rd_data_o
);
  localparam int MUL_ITERS = WIDTH / MUL_STEP;
  localparam int DIV_ITERS = WIDTH;
  localparam int CNT_W     = $clog2(DIV_ITERS + 1);

  md_op_e op;
  logic   accept, is_mul, is_div, sgn, launch;
  logic [WIDTH-1:0] mag_a, mag_b;
  logic [CNT_W-1:0] iters;
  logic   step, fix;

  logic   kind_div_q, neg_main_q, neg_rem_q, dz_q;
  logic [WIDTH-1:0] hi_q, lo_q;

  logic [2*WIDTH-1:0] prod, prod_fix;
  logic [WIDTH-1:0]   quo, rem, quo_fix, rem_fix;

  assign op     = md_op_e'(op_i);
  assign accept = start_i && !busy_o;
  assign is_mul = (op == OP_MUL_S) || (op == OP_MUL_U);
  assign is_div = (op == OP_DIV_S) || (op == OP_DIV_U);
  assign sgn    = (op == OP_MUL_S) || (op == OP_DIV_S);
  assign launch = accept && (is_mul || is_div);
  assign mag_a  = (sgn && opa_i[WIDTH-1]) ? (~opa_i + 1'b1) : opa_i;
  assign mag_b  = (sgn && opb_i[WIDTH-1]) ? (~opb_i + 1'b1) : opb_i;
  assign iters  = is_div ? CNT_W'(DIV_ITERS - 1) : CNT_W'(MUL_ITERS - 1);

  muldiv_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .launch_i (launch),
    .iters_i  (iters),
    .step_o   (step),
    .fix_o    (fix),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  muldiv_mul #(.W(WIDTH), .STEP(MUL_STEP)) u_mul (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (launch && is_mul),
    .step_i   (step && !kind_div_q),
    .mcand_i  (mag_a),
    .mplier_i (mag_b),
    .prod_o   (prod)
  );

  muldiv_div #(.W(WIDTH)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (launch && is_div),
    .step_i (step && kind_div_q),
    .dvd_i  (mag_a),
    .dvs_i  (mag_b),
    .quo_o  (quo),
    .rem_o  (rem)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_div_q <= 1'b0;
      neg_main_q <= 1'b0;
      neg_rem_q  <= 1'b0;
      dz_q       <= 1'b0;
    end else if (launch) begin
      kind_div_q <= is_div;
      neg_main_q <= sgn && (opa_i[WIDTH-1] ^ opb_i[WIDTH-1]);
      neg_rem_q  <= sgn && opa_i[WIDTH-1];
      dz_q       <= is_div && (opb_i == '0);
    end
  end

  // sign fix-up on the final cycle
  assign prod_fix = neg_main_q ? (~prod + 1'b1) : prod;
  assign quo_fix  = neg_main_q ? (~quo + 1'b1)  : quo;
  assign rem_fix  = neg_rem_q  ? (~rem + 1'b1)  : rem;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (fix) begin
      if (!kind_div_q) begin
        hi_q <= prod_fix[2*WIDTH-1:WIDTH];
        lo_q <= prod_fix[WIDTH-1:0];
      end else if (!dz_q) begin
        hi_q <= rem_fix;
        lo_q <= quo_fix;
      end
    end else if (accept && op == OP_SET_HI) begin
      hi_q <= opa_i;
    end else if (accept && op == OP_SET_LO) begin
      lo_q <= opa_i;
    end
  end

  assign rd_data_o = rd_hi_i ? hi_q : lo_q;

  p_hilo_frozen_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> ($stable(hi_q) && $stable(lo_q)));
  p_dz_keeps_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && dz_q) |-> ($stable(hi_q) && $stable(lo_q)));
  p_set_hi_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && op_i == 3'd4) |=> (hi_q == $past(opa_i)) && !busy_o);
  p_set_lo_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && op_i == 3'd5) |=> (lo_q == $past(opa_i)) && !busy_o);
  p_launch_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && op_i <= 3'd3) |=> busy_o);
endmodule

// File: tb/muldiv_unit_bench.sv
`timescale 1ns/1ps
module muldiv_unit_bench;
  localparam int DIV_LAT = 33;
  localparam int MUL_LAT = 9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [31:0] opa = '0, opb = '0;
  logic        rd_hi;
  logic        busy, done;
  logic [31:0] rd_data;

  int cyc = 0;
  int checks = 0;
  int failures = 0;

  logic [31:0] m_hi = '0, m_lo = '0;

  logic [31:0] q_hi[$], q_lo[$];
  int          q_due[$];
  string       q_tag[$];
  logic [31:0] r_hi[$], r_lo[$];
  string       r_tag[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  muldiv_unit u_muldiv_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
    .opa_i(opa), .opb_i(opb), .rd_hi_i(rd_hi),
    .busy_o(busy), .done_o(done), .rd_data_o(rd_data)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] model(logic [2:0] o, logic [31:0] a, logic [31:0] b,
                                        logic [63:0] cur);
    longint sa, sb, q, r;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    case (o)
      3'd0: return 64'(sa * sb);
      3'd1: return {32'b0, a} * {32'b0, b};
      3'd2: begin
        if (b == 0) return cur;
        q = sa / sb;
        r = sa % sb;
        return {r[31:0], q[31:0]};
      end
      3'd3: begin
        if (b == 0) return cur;
        return {a % b, a / b};
      end
      default: return cur;
    endcase
  endfunction

  // monitor: pops the scoreboard on done, serves read-back requests otherwise
  initial begin
    logic [31:0] h, l, eh, el;
    int due;
    string tag;
    rd_hi = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        if (q_due.size() == 0) begin
          chk("R11 unexpected done", 32'd1, 32'd0);
        end else begin
          eh = q_hi.pop_front(); el = q_lo.pop_front();
          due = q_due.pop_front(); tag = q_tag.pop_front();
          chk({tag, " R10 done cycle"}, 32'(cyc), 32'(due));
          chk({tag, " R10 busy low at done"}, {31'b0, busy}, 32'd0);
          rd_hi = 1'b1; #1 h = rd_data;
          rd_hi = 1'b0; #1 l = rd_data;
          chk({tag, " HI"}, h, eh);
          chk({tag, " LO"}, l, el);
        end
      end else if (r_tag.size() != 0) begin
        eh = r_hi.pop_front(); el = r_lo.pop_front(); tag = r_tag.pop_front();
        rd_hi = 1'b1; #1 h = rd_data;
        rd_hi = 1'b0; #1 l = rd_data;
        chk({tag, " R9 HI read"}, h, eh);
        chk({tag, " R9 LO read"}, l, el);
      end
    end
  end

  task automatic drain();
    while (q_due.size() != 0 || r_tag.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic readback(string tag);
    r_hi.push_back(m_hi); r_lo.push_back(m_lo); r_tag.push_back(tag);
    drain();
  endtask

  task automatic run_long(logic [2:0] o, logic [31:0] a, logic [31:0] b, string tag);
    logic [63:0] e;
    @(negedge clk);
    start = 1'b1; op = o; opa = a; opb = b;
    e = model(o, a, b, {m_hi, m_lo});
    m_hi = e[63:32]; m_lo = e[31:0];
    q_hi.push_back(m_hi); q_lo.push_back(m_lo); q_tag.push_back(tag);
    q_due.push_back(cyc + 1 + ((o >= 3'd2) ? DIV_LAT : MUL_LAT));
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R10 busy after accept"}, {31'b0, busy}, 32'd1);
    drain();
  endtask

  task automatic run_move(logic hi_sel, logic [31:0] a, string tag);
    @(negedge clk);
    start = 1'b1; op = hi_sel ? 3'd4 : 3'd5; opa = a; opb = '0;
    if (hi_sel) m_hi = a; else m_lo = a;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R8 no busy"}, {31'b0, busy}, 32'd0);
    readback(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", {31'b0, busy}, 32'd0);
    chk("R1 done", {31'b0, done}, 32'd0);
    readback("R1 reset value");

    run_long(3'd0, 32'd7, 32'hFFFF_FFFD, "R2 7*-3");
    run_long(3'd0, 32'h8000_0000, 32'h8000_0000, "R2 min*min");
    run_long(3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 -1*-1");
    run_long(3'd0, 32'h1234_5678, 32'hFEDC_BA98, "R2 mixed");
    run_long(3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 max*max");
    run_long(3'd1, 32'h1234_5678, 32'h9ABC_DEF0, "R3 pattern");

    run_long(3'd2, 32'hFFFF_FFF9, 32'd2, "R4 -7/2");
    run_long(3'd2, 32'd7, 32'hFFFF_FFFE, "R4 7/-2");
    run_long(3'd2, 32'd100, 32'd7, "R4 100/7");
    run_long(3'd2, 32'hFFFF_FF9C, 32'hFFFF_FFF9, "R4 -100/-7");
    run_long(3'd3, 32'hFFFF_FFFF, 32'd3, "R5 max/3");
    run_long(3'd3, 32'd5, 32'd7, "R5 5/7");
    run_long(3'd3, 32'h8000_0001, 32'hFFFF_FFFF, "R5 big/max");

    run_move(1'b1, 32'hDEAD_BEEF, "R8 set HI");
    run_move(1'b0, 32'h0BAD_F00D, "R8 set LO");
    run_long(3'd2, 32'd1234, 32'd0, "R6 signed div by zero");
    run_long(3'd3, 32'hFFFF_0000, 32'd0, "R6 unsigned div by zero");

    run_long(3'd2, 32'h8000_0000, 32'hFFFF_FFFF, "R7 min/-1");

    // R11: strobes during a divide are ignored
    @(negedge clk);
    start = 1'b1; op = 3'd3; opa = 32'd1000; opb = 32'd7;
    begin
      logic [63:0] e;
      e = model(3'd3, 32'd1000, 32'd7, {m_hi, m_lo});
      m_hi = e[63:32]; m_lo = e[31:0];
    end
    q_hi.push_back(m_hi); q_lo.push_back(m_lo); q_tag.push_back("R11 divide under strobes");
    q_due.push_back(cyc + 1 + DIV_LAT);
    @(negedge clk); start = 1'b0;
    @(negedge clk); start = 1'b1; op = 3'd0; opa = 32'd3; opb = 32'd5;
    @(negedge clk); start = 1'b1; op = 3'd4; opa = 32'h1111_1111;
    @(negedge clk); start = 1'b1; op = 3'd5; opa = 32'h2222_2222;
    @(negedge clk); start = 1'b0;
    drain();
    repeat (12) @(negedge clk);
    readback("R11 after ignored strobes");

    // R12: reserved codes
    for (int c = 6; c <= 7; c++) begin
      @(negedge clk);
      start = 1'b1; op = 3'(c); opa = 32'h5555_5555; opb = 32'd1;
      @(negedge clk);
      start = 1'b0;
      chk("R12 reserved no busy", {31'b0, busy}, 32'd0);
      repeat (12) @(negedge clk);
      readback("R12 reserved no change");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL R10 watchdog act=hung exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule